// File: doc/BRIEF.md
# Interleaved DRAM Range Decoder

This block steers physical memory requests to one of eight home nodes. Software programs up to eight address windows, each described by a pair of 32-bit registers: a start word and an end word. The start word holds read and write permission bits and an interleave mode. The end word holds the destination node and the interleave selector value. Each window covers physical address bits 39:24, so it has a granularity of 16 MiB across a 40-bit space.

A request carries a 40-bit address and a write flag. It enters on a valid/ready port. The block compares the request against all eight windows in parallel and returns a registered response one cycle after acceptance. The response carries a hit or miss indication, the winning window index and a 3-bit node ID. When a window is interleaved, it claims only those addresses whose bits 14:12, filtered by the window's mode, equal the selector stored in its end word. Several windows that share one address span can therefore split the span across 2, 4 or 8 nodes.

Back-pressure rules are as follows. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is held, or when the held response is being taken in the same cycle. A response stays valid and unchanged until it is taken on an edge with `rsp_ready` high. The configuration port is a plain port with no handshake. A write takes effect at the next clock edge. A read returns the addressed register combinationally.

Top module: `dram_ilv_decoder`

## Requirements
- R1: After reset, `rsp_valid` and `cfg_error` are 0, and every register reads back as 0.
- R2: Only the defined fields are stored. In the start word these are bits [31:16] (window start), [10:8] (interleave mode), bit 1 (write permit) and bit 0 (read permit). In the end word these are bits [31:16] (window end), [10:8] (selector) and [2:0] (node). All other bits read back as 0.
- R3: A window matches when the request address bits 39:24 are no lower than its start and no higher than its end. Both ends are inclusive.
- R4: A read (`req_is_write`=0) can hit a window only when that window's read permit is set. A write can hit only when the window's write permit is set.
- R5: The interleave mode decides which request address bits must equal the corresponding selector bits. Mode 000 checks none. Mode 001 checks bit 12. Mode 011 checks bits 12 and 14, and bit 13 is ignored. Mode 111 checks bits 14:12.
- R6: A window whose mode is 010, 100, 101 or 110 never matches. Writing such a mode into any start word sets `cfg_error`, which stays set until reset.
- R7: When several windows match, the response reports the lowest-numbered one.
- R8: When no window matches, the response has `rsp_miss`=1, `rsp_hit`=0, and `rsp_node` and `rsp_range` both 0. On a hit, `rsp_hit`=1 and `rsp_miss`=0.
- R9: `rsp_valid` rises on the first edge after acceptance. While `rsp_ready` is low, the response is held unchanged and `req_ready` is 0.
- R10: On a hit, `rsp_node` equals bits [2:0] of the winning window's end word, and `rsp_range` equals that window's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Window index for write and read |
| cfg_end_sel | input | 1 | 0 selects the start word, 1 selects the end word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the addressed word |
| cfg_error | output | 1 | Sticky flag: a reserved interleave mode was written |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 40 | Physical request address |
| req_is_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Request matched a window |
| rsp_miss | output | 1 | Request matched no window |
| rsp_range | output | 3 | Index of the winning window |
| rsp_node | output | 3 | Destination node of the winning window |

## Verification
The bench probes both edges of a window and the addresses just outside it. A comparator that is off by one would either drop the end block or claim the neighbouring block. Interleave mode 011 is tested with bit 13 both high and low. A decoder that mapped the mode bits straight onto address bits 14:12 would wrongly check bit 13 and lose half of the window. Two overlapping windows are also probed. If the priority is reversed, the higher window's node is returned. A reserved mode is tested to show that it neither matches nor fails to raise the sticky error. Finally, a stalled response is held for several cycles to show that it does not change or get overwritten by a new request.

// File: rtl/dram_ilv_pkg.sv
package dram_ilv_pkg;
  localparam int RANGES   = 8;
  localparam int ADDR_W   = 40;
  localparam int WIN_LSB  = 24;
  localparam int WIN_W    = ADDR_W - WIN_LSB;
  localparam int IDX_W    = $clog2(RANGES);
  localparam int NODE_W   = 3;
  localparam int ILV_LSB  = 12;
  localparam int ILV_W    = 3;
  localparam int DATA_W   = 32;

  typedef struct packed {
    logic [WIN_W-1:0] start;
    logic [ILV_W-1:0] mode;
    logic             wr_ok;
    logic             rd_ok;
  } win_start_t;

  typedef struct packed {
    logic [WIN_W-1:0]  stop;
    logic [ILV_W-1:0]  sel;
    logic [NODE_W-1:0] node;
  } win_end_t;

  // Decode an interleave mode into the mask of checked address bits.
  function automatic logic [ILV_W:0] ilv_decode(input logic [ILV_W-1:0] mode);
    // returns {legal, mask}
    case (mode)
      3'b000:  return {1'b1, 3'b000};
      3'b001:  return {1'b1, 3'b001};
      3'b011:  return {1'b1, 3'b101};
      3'b111:  return {1'b1, 3'b111};
      default: return {1'b0, 3'b000};
    endcase
  endfunction
endpackage

// File: rtl/dram_ilv_regs.sv
module dram_ilv_regs
  import dram_ilv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic              end_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output win_start_t        starts [RANGES],
  output win_end_t          ends   [RANGES]
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[15:11], wdata[7:3]};

  logic [ILV_W:0] wr_mode_dec;
  assign wr_mode_dec = ilv_decode(wdata[10:8]);

  for (genvar g = 0; g < RANGES; g++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        starts[g] <= '0;
        ends[g]   <= '0;
      end else if (wr && idx == IDX_W'(g)) begin
        if (end_sel)
          ends[g] <= '{stop: wdata[31:16], sel: wdata[10:8], node: wdata[2:0]};
        else
          starts[g] <= '{start: wdata[31:16], mode: wdata[10:8],
                         wr_ok: wdata[1], rd_ok: wdata[0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err <= 1'b0;
    else if (wr && !end_sel && !wr_mode_dec[ILV_W])
      err <= 1'b1;
  end

  always_comb begin
    if (end_sel)
      rdata = {ends[idx].stop, 5'b0, ends[idx].sel, 5'b0, ends[idx].node};
    else
      rdata = {starts[idx].start, 5'b0, starts[idx].mode, 6'b0,
               starts[idx].wr_ok, starts[idx].rd_ok};
  end
endmodule

// File: rtl/dram_ilv_match.sv
module dram_ilv_match
  import dram_ilv_pkg::*;
(
  input  win_start_t       win_s,
  input  win_end_t         win_e,
  input  logic [WIN_W-1:0] a_win,
  input  logic [ILV_W-1:0] a_ilv,
  input  logic             is_wr,
  output logic             hit
);
  logic [ILV_W:0] dec;
  logic           in_span, perm_ok, ilv_ok;

  always_comb begin
    dec     = ilv_decode(win_s.mode);
    in_span = (a_win >= win_s.start) && (a_win <= win_e.stop);
    perm_ok = is_wr ? win_s.wr_ok : win_s.rd_ok;
    ilv_ok  = dec[ILV_W] && (((a_ilv ^ win_e.sel) & dec[ILV_W-1:0]) == '0);
    hit     = in_span && perm_ok && ilv_ok;
  end
endmodule

// File: rtl/dram_ilv_prio.sv
module dram_ilv_prio
  import dram_ilv_pkg::*;
(
  input  logic [RANGES-1:0] hits,
  output logic              any,
  output logic [IDX_W-1:0]  win_idx
);
  always_comb begin
    any     = |hits;
    win_idx = '0;
    for (int i = RANGES - 1; i >= 0; i--)
      if (hits[i]) win_idx = IDX_W'(i);
  end
endmodule

// File: rtl/dram_ilv_decoder.sv
module dram_ilv_decoder
  import dram_ilv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_end_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_error,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [IDX_W-1:0]  rsp_range,
  output logic [NODE_W-1:0] rsp_node
);
  win_start_t        starts [RANGES];
  win_end_t          ends   [RANGES];
  logic [RANGES-1:0] hits;
  logic              any_hit;
  logic [IDX_W-1:0]  best;
  logic              accept;

  logic unused_abits;
  assign unused_abits = ^{req_addr[WIN_LSB-1:ILV_LSB+ILV_W], req_addr[ILV_LSB-1:0]};

  dram_ilv_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idx(cfg_idx), .end_sel(cfg_end_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .err(cfg_error),
    .starts(starts), .ends(ends)
  );

  for (genvar g = 0; g < RANGES; g++) begin : g_cmp
    dram_ilv_match u_match (
      .win_s(starts[g]), .win_e(ends[g]),
      .a_win(req_addr[ADDR_W-1:WIN_LSB]),
      .a_ilv(req_addr[ILV_LSB+ILV_W-1:ILV_LSB]),
      .is_wr(req_is_write), .hit(hits[g])
    );
  end

  dram_ilv_prio u_prio (.hits(hits), .any(any_hit), .win_idx(best));

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_range <= '0;
      rsp_node  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= any_hit;
      rsp_miss  <= !any_hit;
      rsp_range <= any_hit ? best : '0;
      rsp_node  <= any_hit ? ends[best].node : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_ilv_decoder_chk.sv
module dram_ilv_decoder_chk
  import dram_ilv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_error,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic [IDX_W-1:0]  rsp_range,
  input logic [NODE_W-1:0] rsp_node
);
  // R8: a response is exactly one of hit or miss
  p_hit_xor_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));

  // R8: a miss reports zero node and index
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_node == '0 && rsp_range == '0));

  // R9: accepted request yields a response on the next edge
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9: stalled response is held unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_node)
      && $stable(rsp_range) && $stable(rsp_hit)));

  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> cfg_error);
endmodule

bind dram_ilv_decoder dram_ilv_decoder_chk u_chk (.*);

// File: tb/dram_ilv_decoder_tb.sv
module dram_ilv_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic        cfg_end_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_error;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_addr = '0;
  logic        req_is_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_miss;
  logic [2:0]  rsp_range, rsp_node;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  dram_ilv_decoder u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input bit end_w, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 3'(idx); cfg_end_sel = end_w; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input int idx, input bit end_w, output logic [31:0] d);
    @(negedge clk);
    cfg_idx = 3'(idx); cfg_end_sel = end_w;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [39:0] mk_addr(input logic [15:0] hi, input logic [2:0] b14_12);
    return {hi, 9'h0, b14_12, 12'h0};
  endfunction

  // Returns {valid, hit, miss, range, node}
  task automatic do_req(input logic [39:0] a, input bit wr, output logic [8:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    r = {rsp_valid, rsp_hit, rsp_miss, rsp_range, rsp_node};
  endtask

  function automatic logic [8:0] hit_of(input int rng, input int node);
    return {1'b1, 1'b1, 1'b0, 3'(rng), 3'(node)};
  endfunction
  localparam logic [8:0] MISS = {1'b1, 1'b0, 1'b1, 3'd0, 3'd0};

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rsp_valid", 64'(rsp_valid), 0);
    check("R1 cfg_error", 64'(cfg_error), 0);
    cfg_read(0, 0, d); check("R1 start0", 64'(d), 0);
    cfg_read(7, 1, d); check("R1 end7", 64'(d), 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    cfg_write(0, 0, 32'hFFFF_FFFF);
    cfg_write(0, 1, 32'hFFFF_FFFF);
    cfg_read(0, 0, d); check("R2 start fields", 64'(d), 64'hFFFF_0703);
    cfg_read(0, 1, d); check("R2 end fields", 64'(d), 64'hFFFF_0707);
    cfg_write(0, 0, 32'h0);
    cfg_write(0, 1, 32'h0);
    cfg_read(0, 0, d); check("R2 cleared", 64'(d), 0);
  endtask

  task automatic t_window();
    logic [8:0] r;
    cfg_write(1, 1, 32'h001F_0005);
    cfg_write(1, 0, 32'h0010_0003);
    do_req(mk_addr(16'h0010, 3'd0), 0, r); check("R3 low edge", 64'(r), 64'(hit_of(1, 5)));
    do_req(mk_addr(16'h001F, 3'd7), 1, r); check("R3 high edge R10", 64'(r), 64'(hit_of(1, 5)));
    do_req(mk_addr(16'h0020, 3'd0), 0, r); check("R3 above R8", 64'(r), 64'(MISS));
    do_req(mk_addr(16'h000F, 3'd0), 0, r); check("R3 below R8", 64'(r), 64'(MISS));
  endtask

  task automatic t_perm();
    logic [8:0] r;
    cfg_write(2, 1, 32'h0100_0003);
    cfg_write(2, 0, 32'h0100_0001);
    do_req(mk_addr(16'h0100, 3'd0), 0, r); check("R4 read permitted", 64'(r), 64'(hit_of(2, 3)));
    do_req(mk_addr(16'h0100, 3'd0), 1, r); check("R4 write blocked", 64'(r), 64'(MISS));
  endtask

  task automatic t_interleave();
    logic [8:0] r;
    cfg_write(3, 1, 32'h0200_0106);
    cfg_write(3, 0, 32'h0200_0103);
    do_req(mk_addr(16'h0200, 3'b001), 0, r); check("R5 mode001 match", 64'(r), 64'(hit_of(3, 6)));
    do_req(mk_addr(16'h0200, 3'b110), 0, r); check("R5 mode001 reject", 64'(r), 64'(MISS));
    cfg_write(4, 1, 32'h0300_0502);
    cfg_write(4, 0, 32'h0300_0303);
    do_req(mk_addr(16'h0300, 3'b101), 0, r); check("R5 mode011 match", 64'(r), 64'(hit_of(4, 2)));
    do_req(mk_addr(16'h0300, 3'b111), 0, r); check("R5 mode011 bit13 ignored", 64'(r), 64'(hit_of(4, 2)));
    do_req(mk_addr(16'h0300, 3'b001), 0, r); check("R5 mode011 bit14 reject", 64'(r), 64'(MISS));
    cfg_write(5, 1, 32'h0400_0607);
    cfg_write(5, 0, 32'h0400_0703);
    do_req(mk_addr(16'h0400, 3'b110), 1, r); check("R5 mode111 match", 64'(r), 64'(hit_of(5, 7)));
    do_req(mk_addr(16'h0400, 3'b111), 1, r); check("R5 mode111 reject", 64'(r), 64'(MISS));
  endtask

  task automatic t_priority();
    logic [8:0] r;
    cfg_write(6, 1, 32'h0015_0001);
    cfg_write(6, 0, 32'h0015_0003);
    do_req(mk_addr(16'h0015, 3'd0), 0, r); check("R7 lowest wins", 64'(r), 64'(hit_of(1, 5)));
    cfg_write(1, 0, 32'h0010_0000);
    do_req(mk_addr(16'h0015, 3'd0), 0, r); check("R7 next window", 64'(r), 64'(hit_of(6, 1)));
  endtask

  task automatic t_reserved();
    logic [8:0] r;
    check("R6 error clear before", 64'(cfg_error), 0);
    cfg_write(7, 1, 32'h0500_0004);
    cfg_write(7, 0, 32'h0500_0203);
    check("R6 error set", 64'(cfg_error), 1);
    do_req(mk_addr(16'h0500, 3'd0), 0, r); check("R6 reserved no match", 64'(r), 64'(MISS));
    cfg_write(7, 0, 32'h0);
    check("R6 error sticky", 64'(cfg_error), 1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = mk_addr(16'h0100, 3'd0); req_is_write = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk_addr(16'h0400, 3'b110);
    check("R9 valid after one edge", 64'(rsp_valid), 1);
    check("R9 ready low while held", 64'(req_ready), 0);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 held node", 64'({rsp_valid, rsp_range, rsp_node}), 64'({1'b1, 3'd2, 3'd3}));
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 drained", 64'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_window();
    t_perm();
    t_interleave();
    t_priority();
    t_reserved();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule